// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialer with Flash

This block turns one dialled digit into a train of timed loop breaks on a dial-pulse output. While a digit is being sent it also holds a mute output active. It is also used to send a timed flash break and a fixed-length pause, and it raises a one-cycle done flag when each operation ends.

All timing is counted in milliseconds from a tick input derived from the system clock. The user picks the pulse rate (10 or 20 pulses per second) and the make/break ratio. The ratio comes from a strap input with three useful states: one selects tone mode, where digits produce no pulses, and the other two select the two pulse ratios. A flash break drives the pulse line in every mode, tone mode included. Digit storage and keypad decoding lie outside the block.

Top module: `pulse_dialer`

## Requirements
- R1: After reset, dp_on, mute_on and done are all low.
- R2: In a pulse mode, a start with digit code 1 to 9 produces that many breaks, and code 0 produces 10 breaks. Codes 10 to 15 are ignored: no break, no mute and no done.
- R3: At 10 pps, mode_strap 2'b01 (40:60) gives breaks of 60 ms and makes of 40 ms. mode_strap 2'b10 or 2'b11 (33:67) gives breaks of 67 ms and makes of 33 ms.
- R4: With rate20 high, the break is half the 10 pps break and the period is halved. This gives 30/20 ms for 40:60 and 33/17 ms for 33:67.
- R5: After the last break, the line stays made for 800 ms. Then done is high for exactly one cycle, in the same cycle that mute_on falls.
- R6: A flash request holds dp_on high continuously for 73, 100, 300 or 600 ms when flash_sel is 2'b00, 2'b01, 2'b10 or 2'b11. This applies in every mode_strap setting, tone mode included, and done follows.
- R7: A pause request holds mute_on high for 1000 ms with dp_on low, then asserts done.
- R8: mute_on is high from the cycle after a request is accepted until the operation ends, and low at all other times. dp_on is never high while mute_on is low.
- R9: In tone mode (mode_strap 2'b00), a start has no effect on dp_on, mute_on or done.
- R10: Requests are taken only while idle, and any request made during an operation is ignored. When several requests arrive together, flash wins over pause and pause wins over a digit.
- R11: The timers advance only on cycles with ms_tick high, so spacing out the ticks stretches every interval in proportion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| digit | input | 4 | Digit code to dial (0 means ten) |
| start | input | 1 | Start dialing the digit |
| rate20 | input | 1 | 1: 20 pps, 0: 10 pps |
| mode_strap | input | 2 | 00 tone, 01 pulse 40:60, 10/11 pulse 33:67 |
| flash_req | input | 1 | Start a flash break |
| flash_sel | input | 2 | Flash length select |
| pause_req | input | 1 | Start a 1000 ms pause |
| dp_on | output | 1 | High while the line is broken |
| mute_on | output | 1 | High during any operation |
| done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
The bench uses the default parameters, which are the real millisecond values. With ms_tick held high, one cycle equals one millisecond, so every break, make, gap, flash and pause length can be measured exactly in cycles. That includes the 10-break digit and the 600 ms flash. One scenario ticks on every other cycle and checks that the makes and the gap exactly double. Further scenarios inject competing requests during an operation and while idle, to check that busy requests are ignored and that simultaneous requests are ranked as R10 states.

// File: rtl/pulse_dialer.sv
module pulse_dialer #(
  parameter int BRK_A    = 60,
  parameter int MAKE_A   = 40,
  parameter int BRK_B    = 67,
  parameter int MAKE_B   = 33,
  parameter int GAP_MS   = 800,
  parameter int PAUSE_MS = 1000,
  parameter int FL0      = 73,
  parameter int FL1      = 100,
  parameter int FL2      = 300,
  parameter int FL3      = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic [3:0] digit,
  input  logic       start,
  input  logic       rate20,
  input  logic [1:0] mode_strap,
  input  logic       flash_req,
  input  logic [1:0] flash_sel,
  input  logic       pause_req,
  output logic       dp_on,
  output logic       mute_on,
  output logic       done
);
  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXL = max2(max2(PAUSE_MS, GAP_MS),
                             max2(max2(FL3, FL2), max2(BRK_A + MAKE_A, BRK_B + MAKE_B)));
  localparam int CW = $clog2(MAXL + 1);

  typedef enum logic [2:0] {S_IDLE, S_BRK, S_MAKE, S_GAP, S_FLASH, S_PAUSE} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [3:0]    left;
  int            b_sel, m_sel, f_sel;
  logic [CW-1:0] brk_len, make_len, fl_len;
  logic          tone, valid;
  logic [3:0]    npulse;

  assign tone    = (mode_strap == 2'b00);
  assign valid   = (digit <= 4'd9);
  assign npulse  = (digit == 4'd0) ? 4'd10 : digit;
  assign dp_on   = (state == S_BRK) || (state == S_FLASH);
  assign mute_on = (state != S_IDLE);

  always_comb begin
    b_sel = (mode_strap == 2'b01) ? BRK_A  : BRK_B;
    m_sel = (mode_strap == 2'b01) ? MAKE_A : MAKE_B;
    brk_len  = CW'(rate20 ? b_sel / 2 : b_sel);
    make_len = CW'(rate20 ? (b_sel + m_sel) / 2 - b_sel / 2 : m_sel);
    case (flash_sel)
      2'b00:   f_sel = FL0;
      2'b01:   f_sel = FL1;
      2'b10:   f_sel = FL2;
      default: f_sel = FL3;
    endcase
    fl_len = CW'(f_sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      left  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (flash_req) begin
          state <= S_FLASH;
          cnt   <= fl_len - CW'(1);
        end else if (pause_req) begin
          state <= S_PAUSE;
          cnt   <= CW'(PAUSE_MS - 1);
        end else if (start && !tone && valid) begin
          state <= S_BRK;
          cnt   <= brk_len - CW'(1);
          left  <= npulse;
        end
      end else if (ms_tick) begin
        if (cnt != '0) begin
          cnt <= cnt - CW'(1);
        end else begin
          case (state)
            S_BRK: begin
              left <= left - 4'd1;
              if (left == 4'd1) begin
                state <= S_GAP;
                cnt   <= CW'(GAP_MS - 1);
              end else begin
                state <= S_MAKE;
                cnt   <= make_len - CW'(1);
              end
            end
            S_MAKE: begin
              state <= S_BRK;
              cnt   <= brk_len - CW'(1);
            end
            default: begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  // R8
  dp_in_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_on |-> mute_on);

  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mute_on) && !mute_on));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  tone_no_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && tone && !flash_req) |=> !dp_on);

  // R11
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_on && !ms_tick) |=> ($stable(cnt) && $stable(state)));

  // R2
  make_has_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MAKE) |-> (left != 4'd0 && left <= 4'd9));
endmodule

// File: tb/tb_pulse_dialer.sv
module tb_pulse_dialer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b1;
  logic [3:0] digit = 4'd0;
  logic       start = 1'b0;
  logic       rate20 = 1'b0;
  logic [1:0] mode_strap = 2'b01;
  logic       flash_req = 1'b0;
  logic [1:0] flash_sel = 2'b00;
  logic       pause_req = 1'b0;
  logic       dp_on, mute_on, done;
  logic       tick_div = 1'b0;

  int checks = 0;
  int errors = 0;

  int nbrk, nmk, gap, mute_cyc, done_seen, done_mute;
  int brk_len [16];
  int mk_len  [16];

  pulse_dialer dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .digit(digit), .start(start),
    .rate20(rate20), .mode_strap(mode_strap), .flash_req(flash_req),
    .flash_sel(flash_sel), .pause_req(pause_req),
    .dp_on(dp_on), .mute_on(mute_on), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) ms_tick <= tick_div ? ~ms_tick : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_reqs();
    start = 1'b0; flash_req = 1'b0; pause_req = 1'b0;
  endtask

  task automatic measure(input int inject_at);
    int prev, run;
    nbrk = 0; nmk = 0; gap = 0; mute_cyc = 0; done_seen = 0; done_mute = 1;
    prev = 0; run = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      clear_reqs();
      if (done) begin
        done_seen = 1;
        done_mute = mute_on;
        break;
      end
      if (!mute_on) break;
      mute_cyc++;
      if (mute_cyc == 1) begin
        prev = dp_on; run = 1;
      end else if (dp_on == prev) begin
        run++;
      end else begin
        if (prev == 1) begin
          if (nbrk < 16) brk_len[nbrk] = run;
          nbrk++;
        end else if (nbrk > 0) begin
          if (nmk < 16) mk_len[nmk] = run;
          nmk++;
        end
        prev = dp_on; run = 1;
      end
      if (inject_at > 0 && mute_cyc == inject_at) begin
        digit = 4'd9; start = 1'b1; flash_req = 1'b1; pause_req = 1'b1;
      end
    end
    if (mute_cyc > 0) begin
      if (prev == 1) begin
        if (nbrk < 16) brk_len[nbrk] = run;
        nbrk++;
      end else gap = run;
    end
    @(negedge clk);
    check(done == 1'b0, "R5 done lasts one cycle", int'(done), 0);
  endtask

  task automatic dial_and_check(input int d, input logic [1:0] ms, input logic r20,
                                input int exp_b, input int exp_m, input string req, input int inject_at);
    int n;
    n = (d == 0) ? 10 : d;
    mode_strap = ms; rate20 = r20;
    @(negedge clk);
    digit = 4'(d); start = 1'b1;
    measure(inject_at);
    check(nbrk == n, {req, " R2 break count"}, nbrk, n);
    for (int k = 0; k < n && k < 16; k++)
      check(brk_len[k] == exp_b, {req, " break length"}, brk_len[k], exp_b);
    for (int k = 0; k < n - 1 && k < 16; k++)
      check(mk_len[k] == exp_m, {req, " make length"}, mk_len[k], exp_m);
    check(gap == 800, "R5 inter-digit gap", gap, 800);
    check(done_seen == 1 && done_mute == 0, "R5 done with mute low", done_mute, 0);
    check(mute_cyc == n*exp_b + (n-1)*exp_m + 800, "R8 mute span",
          mute_cyc, n*exp_b + (n-1)*exp_m + 800);
  endtask

  task automatic test_reset();
    check(dp_on == 0 && mute_on == 0 && done == 0, "R1 reset outputs",
          int'({dp_on, mute_on, done}), 0);
  endtask

  task automatic test_flash(input logic [1:0] sel, input logic [1:0] ms, input int exp);
    mode_strap = ms;
    @(negedge clk);
    flash_sel = sel; flash_req = 1'b1;
    measure(0);
    check(nbrk == 1 && brk_len[0] == exp, "R6 flash length", (nbrk == 1) ? brk_len[0] : -nbrk, exp);
    check(mute_cyc == exp, "R8 mute during flash", mute_cyc, exp);
    check(done_seen == 1, "R6 done after flash", done_seen, 1);
  endtask

  task automatic test_pause();
    @(negedge clk);
    pause_req = 1'b1;
    measure(0);
    check(nbrk == 0, "R7 no break in pause", nbrk, 0);
    check(gap == 1000 && mute_cyc == 1000, "R7 pause length", mute_cyc, 1000);
    check(done_seen == 1, "R7 done after pause", done_seen, 1);
  endtask

  task automatic test_ignored(input logic [1:0] ms, input int d, input string req);
    int seen;
    seen = 0;
    mode_strap = ms;
    @(negedge clk);
    digit = 4'(d); start = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      clear_reqs();
      if (dp_on || mute_on || done) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic test_priority();
    mode_strap = 2'b01;
    @(negedge clk);
    flash_sel = 2'b01; flash_req = 1'b1; pause_req = 1'b1; digit = 4'd4; start = 1'b1;
    measure(0);
    check(nbrk == 1 && brk_len[0] == 100, "R10 flash wins", (nbrk == 1) ? brk_len[0] : -nbrk, 100);
    @(negedge clk);
    pause_req = 1'b1; digit = 4'd4; start = 1'b1;
    measure(0);
    check(nbrk == 0 && mute_cyc == 1000, "R10 pause wins over digit", mute_cyc, 1000);
  endtask

  task automatic test_tick_div();
    mode_strap = 2'b01; rate20 = 1'b0; tick_div = 1'b1;
    @(negedge clk);
    digit = 4'd2; start = 1'b1;
    measure(0);
    check(nbrk == 2, "R11 break count stretched", nbrk, 2);
    check(mk_len[0] == 80, "R11 make doubled", mk_len[0], 80);
    check(gap == 1600, "R11 gap doubled", gap, 1600);
    tick_div = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    dial_and_check(3, 2'b01, 1'b0, 60, 40, "R3 40:60 10pps", 0);
    dial_and_check(0, 2'b10, 1'b0, 67, 33, "R3 33:67 10pps", 0);
    dial_and_check(7, 2'b01, 1'b1, 30, 20, "R4 40:60 20pps", 0);
    dial_and_check(2, 2'b11, 1'b1, 33, 17, "R4 33:67 20pps", 0);
    dial_and_check(1, 2'b10, 1'b0, 67, 33, "R2 single digit", 0);
    dial_and_check(3, 2'b01, 1'b0, 60, 40, "R10 busy ignore", 90);
    rate20 = 1'b0;
    test_flash(2'b00, 2'b00, 73);
    test_flash(2'b01, 2'b00, 100);
    test_flash(2'b10, 2'b01, 300);
    test_flash(2'b11, 2'b10, 600);
    test_pause();
    test_ignored(2'b00, 5, "R9 tone mode start ignored");
    test_ignored(2'b01, 12, "R2 invalid code ignored");
    test_priority();
    test_tick_div();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule